// File: doc/BRIEF.md
# Display Controller Host Command Port

This block is the processor-facing side of a display controller. It attaches to either an 8080-style bus (separate active-low read and write strobes) or a 6800-style bus (an active-high enable plus a read/write direction line). A static input selects the bus type. An active-low chip select and one address bit qualify every access. Each access is classified as one of four kinds: a status read, a data read, a data or parameter write, or a command write.

A command write sets the current operation and clears the parameter position. Each later parameter write goes into a flat register file that the display logic downstream reads. Two cases are handled differently. Some 16-bit parameters are committed only as complete pairs. Under the memory-streaming commands, the data bytes do not touch the register file: each one is passed to a memory-port block as a one-cycle strobe, and read data is taken back from that block.

Top module: `lcdc_host_port`

## Requirements
- R1: With `bus_mode`=0, `rd_e` is the active-low read strobe and `wr_rw` the active-low write strobe. Read (rd low, wr high): `a0`=0 returns `status_in` and `a0`=1 returns data. Write (rd high, wr low): `a0`=0 is a data or parameter byte and `a0`=1 is a command. A write takes effect when the write strobe rises. `dout_oe` is high only while a qualified read is active.
- R2: With `bus_mode`=1, `rd_e` is the active-high enable and `wr_rw` is high for read and low for write. `a0` has the same meaning as in R1, and a write takes effect when the enable falls.
- R3: A command write stores its byte as the current command, resets the parameter position to 0 and drops any half-received pair. The layout of `regs_o` (byte i at bits 8i+7:8i) is: 0x40 → 0–7, 0x44 → 8–17, 0x5D → 18–19, 0x5C → 20–21, 0x58/0x59 → 22, 0x5A → 23, 0x5B → 24, 0x46 → 25 (low) and 26 (high).
- R4: Each parameter byte updates its register when it arrives. A command that is cut short leaves its unwritten registers at their old values.
- R5: The number of parameter bytes accepted is 8 (0x40), 10 (0x44), 2 (0x5D, 0x5C, 0x46), 1 (0x58, 0x59, 0x5A, 0x5B) and 0 for every other code. Extra bytes change nothing.
- R6: Under 0x44, positions (0,1), (3,4), (6,7) and (8,9) are pairs, and under 0x5C positions (0,1) are a pair. A pair is written only when its second byte arrives. A first byte followed by a command write is discarded.
- R7: The cursor address (0x46) commits byte by byte, so writing only the low byte is allowed. Under 0x47, successive data reads return the cursor low byte, then the high byte, then 0.
- R8: While `cs_n` is high, all strobes are ignored.
- R9: Under 0x42, each data write pulses `mem_wr_stb` for one cycle with the byte on `mem_wr_data`, with no limit on the count. Under 0x43, a data read returns `mem_rdata` and, when it ends, pulses `mem_rd_stb` once.
- R10: Synchronous active-low reset sets `cur_cmd` to 0x00 (no command) and clears every register to 0.
- R11: The two system-set bytes at positions 6 and 7 are independent single bytes, so position 6 may be written without position 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | 0: strobe-pair bus, 1: enable plus direction bus |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Access type select |
| rd_e | input | 1 | Read strobe (mode 0) or enable (mode 1) |
| wr_rw | input | 1 | Write strobe (mode 0) or read/write direction (mode 1) |
| din | input | DATA_W | Host write data |
| dout | output | DATA_W | Host read data |
| dout_oe | output | 1 | Read drivers enable |
| status_in | input | DATA_W | Status byte from the display timing logic |
| mem_rdata | input | DATA_W | Read data from the memory port |
| mem_wr_stb | output | 1 | One-cycle memory write request |
| mem_wr_data | output | DATA_W | Memory write byte |
| mem_rd_stb | output | 1 | One-cycle memory read advance |
| cur_cmd | output | DATA_W | Current command code |
| regs_o | output | REG_COUNT*DATA_W | Flat parameter register file |

## Verification
The hardest situation to reach is a paired parameter that is abandoned halfway. It occurs only when a command write lands between the two halves, and the effect is visible only as a register that stays unchanged. The stimulus reaches it by sending exactly one scroll byte and then a different command. It then restarts the address-pair command with a single byte before restarting it again. A later full pair must then show only the new values. The partial system-set and low-byte-only cursor sequences reach the related cases in which a sequence is cut short but the earlier bytes must still land.

// File: rtl/lcdc_host_pkg.sv
package lcdc_host_pkg;
   localparam int NUM_REGS = 27;
   localparam int IDX_W    = 5;

   localparam logic [7:0] OP_NONE     = 8'h00;
   localparam logic [7:0] OP_SYSSET   = 8'h40;
   localparam logic [7:0] OP_MWR      = 8'h42;
   localparam logic [7:0] OP_MRD      = 8'h43;
   localparam logic [7:0] OP_SCROLL   = 8'h44;
   localparam logic [7:0] OP_CURW     = 8'h46;
   localparam logic [7:0] OP_CURR     = 8'h47;
   localparam logic [7:0] OP_DISP_OFF = 8'h58;
   localparam logic [7:0] OP_DISP_ON  = 8'h59;
   localparam logic [7:0] OP_HDOT     = 8'h5A;
   localparam logic [7:0] OP_OVLAY    = 8'h5B;
   localparam logic [7:0] OP_CGADR    = 8'h5C;
   localparam logic [7:0] OP_CSRFORM  = 8'h5D;

   localparam int CUR_LO_REG = 25;
   localparam int CUR_HI_REG = 26;

   // number of parameter bytes a command accepts
   function automatic logic [IDX_W-1:0] op_count(input logic [7:0] op);
      case (op)
         OP_SYSSET:              return 5'd8;
         OP_SCROLL:              return 5'd10;
         OP_CSRFORM, OP_CGADR,
         OP_CURW:                return 5'd2;
         OP_DISP_OFF, OP_DISP_ON,
         OP_HDOT, OP_OVLAY:      return 5'd1;
         default:                return 5'd0;
      endcase
   endfunction

   // first register of the command's slice in the register file
   function automatic logic [IDX_W-1:0] op_base(input logic [7:0] op);
      case (op)
         OP_SYSSET:              return 5'd0;
         OP_SCROLL:              return 5'd8;
         OP_CSRFORM:             return 5'd18;
         OP_CGADR:               return 5'd20;
         OP_DISP_OFF, OP_DISP_ON: return 5'd22;
         OP_HDOT:                return 5'd23;
         OP_OVLAY:               return 5'd24;
         OP_CURW:                return 5'd25;
         default:                return 5'd0;
      endcase
   endfunction

   // position holds the first half of a pair that commits as a whole
   function automatic logic pair_low(input logic [7:0] op, input logic [IDX_W-1:0] idx);
      case (op)
         OP_SCROLL: return (idx == 5'd0) || (idx == 5'd3) || (idx == 5'd6) || (idx == 5'd8);
         OP_CGADR:  return (idx == 5'd0);
         default:   return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/lcdc_bus_decode.sv
module lcdc_bus_decode #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_mode,
   input  logic              cs_n,
   input  logic              a0,
   input  logic              rd_e,
   input  logic              wr_rw,
   input  logic [DATA_W-1:0] din,
   output logic              rd_act,
   output logic              cmd_ev,
   output logic              par_ev,
   output logic              drd_ev,
   output logic [DATA_W-1:0] ev_data
);
   logic wr_act, wr_act_q, a0_q, rdd_act, rdd_q;
   logic [DATA_W-1:0] din_q;

   always_comb begin
      if (!bus_mode) begin
         rd_act = !cs_n && !rd_e &&  wr_rw;
         wr_act = !cs_n &&  rd_e && !wr_rw;
      end else begin
         rd_act = !cs_n &&  rd_e &&  wr_rw;
         wr_act = !cs_n &&  rd_e && !wr_rw;
      end
      rdd_act = rd_act && a0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_act_q <= 1'b0;
         rdd_q    <= 1'b0;
         a0_q     <= 1'b0;
         din_q    <= '0;
      end else begin
         wr_act_q <= wr_act;
         rdd_q    <= rdd_act;
         if (wr_act) begin
            a0_q  <= a0;
            din_q <= din;
         end
      end
   end

   // an access takes effect when its strobe is released
   assign cmd_ev  = wr_act_q && !wr_act &&  a0_q;
   assign par_ev  = wr_act_q && !wr_act && !a0_q;
   assign drd_ev  = rdd_q && !rdd_act;
   assign ev_data = din_q;

   AST_CS_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> (!cmd_ev && !par_ev && !drd_ev)); // R8
endmodule

// File: rtl/lcdc_cmd_seq.sv
module lcdc_cmd_seq
   import lcdc_host_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_ev,
   input  logic              par_ev,
   input  logic              drd_ev,
   input  logic [DATA_W-1:0] ev_data,
   output logic [DATA_W-1:0] cmd_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              we,
   output logic              we_pair,
   output logic [IDX_W-1:0]  waddr,
   output logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] pdata,
   output logic              mem_wr_stb,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              mem_rd_stb
);
   logic [DATA_W-1:0] cmd_q, pend_q;
   logic [IDX_W-1:0]  idx_q;
   logic              pend_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q       <= OP_NONE;
         idx_q       <= '0;
         pend_q      <= '0;
         pend_vld    <= 1'b0;
         we          <= 1'b0;
         we_pair     <= 1'b0;
         waddr       <= '0;
         wdata       <= '0;
         mem_wr_stb  <= 1'b0;
         mem_wr_data <= '0;
         mem_rd_stb  <= 1'b0;
      end else begin
         we         <= 1'b0;
         we_pair    <= 1'b0;
         mem_wr_stb <= 1'b0;
         mem_rd_stb <= 1'b0;
         if (cmd_ev) begin
            cmd_q    <= ev_data;
            idx_q    <= '0;
            pend_vld <= 1'b0;
         end else if (par_ev) begin
            if (cmd_q == OP_MWR) begin
               mem_wr_stb  <= 1'b1;
               mem_wr_data <= ev_data;
            end else if (idx_q < op_count(cmd_q)) begin
               idx_q <= idx_q + 5'd1;
               waddr <= op_base(cmd_q) + idx_q;
               wdata <= ev_data;
               if (pair_low(cmd_q, idx_q)) begin
                  pend_q   <= ev_data;
                  pend_vld <= 1'b1;
               end else if (idx_q != '0 && pair_low(cmd_q, idx_q - 5'd1)) begin
                  we_pair  <= pend_vld;
                  pend_vld <= 1'b0;
               end else begin
                  we <= 1'b1;
               end
            end
         end else if (drd_ev) begin
            if (cmd_q == OP_MRD)
               mem_rd_stb <= 1'b1;
            else if (cmd_q == OP_CURR && idx_q < 5'd2)
               idx_q <= idx_q + 5'd1;
         end
      end
   end

   assign cmd_o = cmd_q;
   assign idx_o = idx_q;
   assign pdata = pend_q;

   AST_IDX_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == OP_CURR) ? (idx_q <= 5'd2) : (idx_q <= op_count(cmd_q))); // R5
   AST_CMD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ev |=> (idx_q == '0 && !pend_vld)); // R3
   AST_MEMWR_UNDER_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_stb |-> (cmd_q == OP_MWR)); // R9
   AST_PAIR_HAS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      we_pair |-> $past(pend_vld)); // R6
endmodule

// File: rtl/lcdc_param_regs.sv
module lcdc_param_regs
   import lcdc_host_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int REG_COUNT = NUM_REGS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic                        we_pair,
   input  logic [IDX_W-1:0]            waddr,
   input  logic [DATA_W-1:0]           wdata,
   input  logic [DATA_W-1:0]           pdata,
   output logic [REG_COUNT*DATA_W-1:0] regs_o
);
   for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            r_q <= '0;
         else if ((we || we_pair) && waddr == IDX_W'(i))
            r_q <= wdata;
         else if (we_pair && waddr == IDX_W'(i + 1))
            r_q <= pdata;
      end
      assign regs_o[i*DATA_W +: DATA_W] = r_q;
   end

   AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && !we_pair) |=> $stable(regs_o)); // R4
endmodule

// File: rtl/lcdc_host_port.sv
module lcdc_host_port
   import lcdc_host_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int REG_COUNT = NUM_REGS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_mode,
   input  logic                        cs_n,
   input  logic                        a0,
   input  logic                        rd_e,
   input  logic                        wr_rw,
   input  logic [DATA_W-1:0]           din,
   output logic [DATA_W-1:0]           dout,
   output logic                        dout_oe,
   input  logic [DATA_W-1:0]           status_in,
   input  logic [DATA_W-1:0]           mem_rdata,
   output logic                        mem_wr_stb,
   output logic [DATA_W-1:0]           mem_wr_data,
   output logic                        mem_rd_stb,
   output logic [DATA_W-1:0]           cur_cmd,
   output logic [REG_COUNT*DATA_W-1:0] regs_o
);
   if (DATA_W != 8) begin : g_bad_width
      $error("lcdc_host_port: command codes need DATA_W of 8");
   end
   if (REG_COUNT < NUM_REGS) begin : g_bad_regs
      $error("lcdc_host_port: REG_COUNT too small for the parameter layout");
   end

   logic              rd_act, cmd_ev, par_ev, drd_ev, we, we_pair;
   logic [DATA_W-1:0] ev_data, wdata, pdata;
   logic [IDX_W-1:0]  idx, waddr;

   lcdc_bus_decode #(.DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .a0(a0),
      .rd_e(rd_e), .wr_rw(wr_rw), .din(din), .rd_act(rd_act),
      .cmd_ev(cmd_ev), .par_ev(par_ev), .drd_ev(drd_ev), .ev_data(ev_data)
   );

   lcdc_cmd_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_ev(cmd_ev), .par_ev(par_ev), .drd_ev(drd_ev),
      .ev_data(ev_data), .cmd_o(cur_cmd), .idx_o(idx), .we(we), .we_pair(we_pair),
      .waddr(waddr), .wdata(wdata), .pdata(pdata), .mem_wr_stb(mem_wr_stb),
      .mem_wr_data(mem_wr_data), .mem_rd_stb(mem_rd_stb)
   );

   lcdc_param_regs #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(we), .we_pair(we_pair), .waddr(waddr),
      .wdata(wdata), .pdata(pdata), .regs_o(regs_o)
   );

   always_comb begin
      dout = '0;
      if (!a0)
         dout = status_in;
      else if (cur_cmd == OP_CURR) begin
         if (idx == 5'd0)      dout = regs_o[CUR_LO_REG*DATA_W +: DATA_W];
         else if (idx == 5'd1) dout = regs_o[CUR_HI_REG*DATA_W +: DATA_W];
      end else if (cur_cmd == OP_MRD)
         dout = mem_rdata;
   end

   assign dout_oe = rd_act;

   AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !dout_oe); // R8
   AST_RDSTB_UNDER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_stb |-> (cur_cmd == OP_MRD)); // R9
endmodule

// File: tb/lcdc_host_port_tb.sv
module lcdc_host_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 27;

   logic clk = 1'b0;
   logic rst_n, bus_mode, cs_n, a0, rd_e, wr_rw;
   logic [7:0] din, dout, status_in, mem_rdata, mem_wr_data, cur_cmd;
   logic dout_oe, mem_wr_stb, mem_rd_stb;
   logic [NR*8-1:0] regs_o;

   int checks = 0, errors = 0, wr_seen = 0, rd_seen = 0;
   logic [7:0] exp_q[$];
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcdc_host_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .a0(a0),
      .rd_e(rd_e), .wr_rw(wr_rw), .din(din), .dout(dout), .dout_oe(dout_oe),
      .status_in(status_in), .mem_rdata(mem_rdata), .mem_wr_stb(mem_wr_stb),
      .mem_wr_data(mem_wr_data), .mem_rd_stb(mem_rd_stb), .cur_cmd(cur_cmd),
      .regs_o(regs_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rb(input int i);
      return regs_o[i*8 +: 8];
   endfunction

   task automatic go_idle();
      cs_n = 1'b1;
      wr_rw = 1'b1;
      rd_e = bus_mode ? 1'b0 : 1'b1;
   endtask

   task automatic bus_wr(input logic ad, input logic [7:0] d, input bit sel = 1);
      @(negedge clk);
      cs_n = !sel; a0 = ad; din = d;
      rd_e = 1'b1; wr_rw = 1'b0;   // mode 0: rd_n high, wr_n low; mode 1: E high, write
      repeat (2) @(negedge clk);
      chk("R1 no drive during write", dout_oe, 0);
      if (bus_mode) rd_e = 1'b0; else wr_rw = 1'b1;
      @(negedge clk);
      go_idle();
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_rd(input logic ad, output logic [7:0] v);
      @(negedge clk);
      cs_n = 1'b0; a0 = ad; wr_rw = 1'b1;
      rd_e = bus_mode ? 1'b1 : 1'b0;
      repeat (2) @(negedge clk);
      v = dout;
      chk("R1 drive during read", dout_oe, 1);
      rd_e = bus_mode ? 1'b0 : 1'b1;
      @(negedge clk);
      go_idle();
      repeat (3) @(negedge clk);
   endtask

   // scoreboard monitor for memory-port strobes
   always @(negedge clk) begin
      if (rst_n === 1'b1 && mem_wr_stb === 1'b1) begin
         wr_seen++;
         if (exp_q.size() == 0) chk("R9 unexpected memory write", 1, 0);
         else chk("R9 streamed byte", mem_wr_data, exp_q.pop_front());
      end
      if (rst_n === 1'b1 && mem_rd_stb === 1'b1) rd_seen++;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [NR*8-1:0] snap;
      rst_n = 1'b0; bus_mode = 1'b0; a0 = 1'b0; din = '0;
      status_in = 8'hA5; mem_rdata = 8'hC3;
      go_idle();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 command cleared", cur_cmd, 8'h00);
      chk("R10 registers cleared", (regs_o == '0), 1);
      chk("R1 idle no drive", dout_oe, 0);

      bus_rd(1'b0, v);
      chk("R1 status read", v, 8'hA5);

      // full system set
      bus_wr(1'b1, 8'h40);
      chk("R3 command stored", cur_cmd, 8'h40);
      for (int k = 0; k < 8; k++) bus_wr(1'b0, 8'h10 + 8'(k));
      for (int k = 0; k < 8; k++) chk("R3 system set byte", rb(k), 8'h10 + 8'(k));
      snap = regs_o;
      bus_wr(1'b0, 8'hEE);
      chk("R5 extra byte ignored", (regs_o == snap), 1);

      // seven bytes only: position 6 lands, position 7 keeps old value
      bus_wr(1'b1, 8'h40);
      for (int k = 0; k < 7; k++) bus_wr(1'b0, 8'h21 + 8'(k));
      chk("R11 pitch low alone", rb(6), 8'h27);
      chk("R11 pitch high kept", rb(7), 8'h17);
      chk("R4 earlier byte updated", rb(0), 8'h21);

      // half pair abandoned by a new command
      bus_wr(1'b1, 8'h44);
      bus_wr(1'b0, 8'hA1);
      chk("R6 lone first half not written", rb(8), 8'h00);
      bus_wr(1'b1, 8'h5B);
      bus_wr(1'b0, 8'h33);
      chk("R6 first half dropped", rb(8), 8'h00);
      chk("R3 overlay register", rb(24), 8'h33);

      // partial scroll
      bus_wr(1'b1, 8'h44);
      bus_wr(1'b0, 8'h11); bus_wr(1'b0, 8'h22); bus_wr(1'b0, 8'h33);
      chk("R6 pair committed low", rb(8), 8'h11);
      chk("R6 pair committed high", rb(9), 8'h22);
      chk("R4 single after pair", rb(10), 8'h33);
      chk("R4 unwritten kept", rb(11), 8'h00);

      // address pair restarted
      bus_wr(1'b1, 8'h5C); bus_wr(1'b0, 8'h10);
      bus_wr(1'b1, 8'h5C); bus_wr(1'b0, 8'h20); bus_wr(1'b0, 8'h30);
      chk("R6 restarted pair low", rb(20), 8'h20);
      chk("R6 restarted pair high", rb(21), 8'h30);

      // cursor low byte only, then read back
      bus_wr(1'b1, 8'h46); bus_wr(1'b0, 8'h34);
      chk("R7 cursor low alone", rb(25), 8'h34);
      chk("R7 cursor high kept", rb(26), 8'h00);
      bus_wr(1'b1, 8'h47);
      bus_rd(1'b1, v); chk("R7 read cursor low", v, 8'h34);
      bus_rd(1'b1, v); chk("R7 read cursor high", v, 8'h00);
      bus_rd(1'b1, v); chk("R7 read past end", v, 8'h00);
      bus_wr(1'b1, 8'h46); bus_wr(1'b0, 8'h78); bus_wr(1'b0, 8'h9A);
      bus_wr(1'b1, 8'h47);
      bus_rd(1'b1, v); chk("R7 read cursor low full", v, 8'h78);
      bus_rd(1'b1, v); chk("R7 read cursor high full", v, 8'h9A);

      // deselected command write is ignored
      bus_wr(1'b1, 8'h5A);
      bus_wr(1'b1, 8'h5B, 0);
      chk("R8 command unchanged", cur_cmd, 8'h5A);
      bus_wr(1'b0, 8'h77);
      chk("R8 byte went to previous command", rb(23), 8'h77);
      chk("R8 overlay untouched", rb(24), 8'h33);

      // memory streaming
      bus_wr(1'b1, 8'h42);
      snap = regs_o;
      for (int k = 0; k < 12; k++) begin
         exp_q.push_back(8'h80 ^ 8'(k * 7));
         bus_wr(1'b0, 8'h80 ^ 8'(k * 7));
      end
      chk("R9 all bytes streamed", wr_seen, 12);
      chk("R9 queue drained", exp_q.size(), 0);
      chk("R9 registers untouched", (regs_o == snap), 1);
      bus_wr(1'b1, 8'h43);
      bus_rd(1'b1, v);
      chk("R9 memory read data", v, 8'hC3);
      chk("R9 read advance pulse", rd_seen, 1);

      // second bus type
      @(negedge clk);
      bus_mode = 1'b1;
      go_idle();
      @(negedge clk);
      bus_wr(1'b1, 8'h59);
      chk("R2 command in mode 1", cur_cmd, 8'h59);
      bus_wr(1'b0, 8'h5A);
      chk("R2 display register", rb(22), 8'h5A);
      status_in = 8'h3C;
      bus_rd(1'b0, v);
      chk("R2 status read", v, 8'h3C);
      bus_wr(1'b1, 8'h47);
      bus_rd(1'b1, v);
      chk("R2 data read", v, 8'h78);
      bus_wr(1'b1, 8'h5B, 0);
      chk("R8 deselected in mode 1", cur_cmd, 8'h47);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule